// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the timing of a synchronous serial link from the system clock. The derivation uses two divisions in cascade. The first is an even prescaler P. The second divides by one plus an 8-bit rate value R. One serial bit therefore lasts P × (1 + R) system clock cycles.

The block produces two outputs. The first, `edge_tick`, is a one-cycle enable pulse that fires twice per bit period, and shift logic uses it to time its launch and capture edges. The second, `sclk`, is a serial clock level that flips on every pulse. When no frame is running, `sclk` rests at the level chosen by `idle_pol`.

P and R are held in two small registers, written and read through a simple select/data interface. A two-state machine governs the generator:
- In `GEN_IDLE`, the counters are held at zero and the working copy of P and R follows the registers.
- In `GEN_RUN`, the counters advance and the working copy is frozen.

The transition `start` (IDLE to RUN) happens when `port_en` and `frame_act` are both high at a clock edge. The transition `stop` (RUN to IDLE) happens when either of them is low at a clock edge.

Top module: `bitrate_gen`

## Requirements
- R1: A write with `wr_sel`=0 stores `wr_data` into the prescale register with bit 0 forced to 0. A read with `rd_sel`=0 returns the stored prescale, and its bit 0 is always 0.
- R2: A write with `wr_sel`=1 stores all 8 bits of `wr_data` as the rate value. A read with `rd_sel`=1 returns that value unchanged, for any value from 0 to 255.
- R3: While running, `edge_tick` is high for one cycle every H = P×(1+R)/2 cycles. Cycles are counted from 1, starting with the cycle after the clock edge at which the run request is first seen. The first pulse falls in cycle H.
- R4: A stored prescale of 0 produces the same timing as a prescale of 2.
- R5: While running, `sclk` inverts in the cycle after each `edge_tick` pulse and holds its value otherwise. The first change after a frame starts moves `sclk` away from the idle level.
- R6: While the generator is not running, `edge_tick` stays 0 and `sclk` equals `idle_pol`.
- R7: The machine enters `GEN_RUN` at a clock edge where `port_en` and `frame_act` are both 1. It returns to `GEN_IDLE` at a clock edge where either is 0. Both counters restart from zero for every frame.
- R8: Prescale or rate writes made during a frame do not change that frame's timing. They take effect from the next frame.
- R9: After reset, the prescale reads 2, the rate reads 0, `edge_tick` is 0 and `sclk` equals `idle_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| frame_act | input | 1 | A frame is in progress |
| idle_pol | input | 1 | Resting level of `sclk` |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 prescale, 1 rate |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 prescale, 1 rate |
| rd_data | output | 8 | Read data |
| edge_tick | output | 1 | Pulse at twice the bit rate |
| sclk | output | 1 | Serial clock level |

## Verification
The divider is exercised with several (P, R) pairs:
- (2, 0) gives a pulse every cycle, which exposes off-by-one errors in either stage.
- (4, 2) and (6, 0) separate the product P×(1+R) from a sum or from a missing halving.
- (254, 1) tests the full prescaler width.
- A stored 0 and an odd write (5, stored as 4) separate the clamp from the LSB clearing.

A frame with writes made in the middle shows whether the working copy stays frozen until the next frame. A frame that restarts immediately checks that the counters are cleared. Both idle polarities are used, so an inverted or stuck `sclk` becomes visible.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    localparam logic SEL_PRESCALE = 1'b0;
    localparam logic SEL_RATE     = 1'b1;

endpackage

// File: rtl/bitrate_cfg_regs.sv
module bitrate_cfg_regs
    import bitrate_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8,
    parameter int RD_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [RD_W-1:0]   wr_data,
    input  logic              rd_sel,
    output logic [RD_W-1:0]   rd_data,
    output logic [PRE_W-1:0]  pre_q,
    output logic [RATE_W-1:0] rate_q
);

    localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= PRE_RST;
            rate_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PRESCALE) begin
                pre_q <= {wr_data[PRE_W-1:1], 1'b0};
            end else begin
                rate_q <= wr_data[RATE_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_PRESCALE: rd_data = RD_W'(pre_q);
            SEL_RATE:     rd_data = RD_W'(rate_q);
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/bitrate_div_stage.sv
module bitrate_div_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] lim,
    output logic         wrap
);

    logic [W-1:0] cnt_q;
    logic         at_lim;

    assign at_lim = (cnt_q == lim);
    assign wrap   = run & step & at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
    import bitrate_pkg::*;
#(
    parameter  int PRE_W  = 8,
    parameter  int RATE_W = 8,
    localparam int RD_W   = (PRE_W > RATE_W) ? PRE_W : RATE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_en,
    input  logic            frame_act,
    input  logic            idle_pol,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [RD_W-1:0] wr_data,
    input  logic            rd_sel,
    output logic [RD_W-1:0] rd_data,
    output logic            edge_tick,
    output logic            sclk
);

    localparam int HALF_W = PRE_W - 1;

    gen_state_e        state_q, state_d;
    logic              run_req;
    logic              running;
    logic              load_cfg;
    logic [PRE_W-1:0]  pre_q;
    logic [RATE_W-1:0] rate_q;
    logic [HALF_W-1:0] half_m1_d;
    logic [HALF_W-1:0] act_half_m1;
    logic [RATE_W-1:0] act_rate;
    logic              pre_tick;
    logic              sclk_q;

    assign run_req = port_en & frame_act;

    bitrate_cfg_regs #(
        .PRE_W (PRE_W),
        .RATE_W(RATE_W),
        .RD_W  (RD_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .pre_q  (pre_q),
        .rate_q (rate_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: start (IDLE->RUN), stop (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: if (run_req)  state_d = GEN_RUN;
            GEN_RUN:  if (!run_req) state_d = GEN_IDLE;
            default:                state_d = GEN_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        running  = 1'b0;
        load_cfg = 1'b0;
        unique case (state_q)
            GEN_IDLE: load_cfg = 1'b1;
            GEN_RUN:  running  = 1'b1;
            default:  load_cfg = 1'b1;
        endcase
    end

    // Half of the prescale, minus one; a stored 0 behaves as 2
    assign half_m1_d = (pre_q[PRE_W-1:1] == '0) ? '0
                                                : pre_q[PRE_W-1:1] - 1'b1;

    // Working copy follows the registers only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_half_m1 <= '0;
            act_rate    <= '0;
        end else if (load_cfg) begin
            act_half_m1 <= half_m1_d;
            act_rate    <= rate_q;
        end
    end

    bitrate_div_stage #(.W(HALF_W)) u_stage_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .step (1'b1),
        .lim  (act_half_m1),
        .wrap (pre_tick)
    );

    bitrate_div_stage #(.W(RATE_W)) u_stage_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .step (pre_tick),
        .lim  (act_rate),
        .wrap (edge_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else if (!running) begin
            sclk_q <= idle_pol;
        end else if (edge_tick) begin
            sclk_q <= ~sclk_q;
        end
    end

    assign sclk = running ? sclk_q : idle_pol;

endmodule

// File: rtl/bitrate_gen_chk.sv
module bitrate_gen_chk #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 8,
    parameter int RD_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              frame_act,
    input logic              idle_pol,
    input logic              rd_sel,
    input logic [RD_W-1:0]   rd_data,
    input logic              edge_tick,
    input logic              sclk,
    input logic              running,
    input logic [PRE_W-2:0]  act_half_m1,
    input logic [RATE_W-1:0] act_rate
);

    // R1
    pre_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 1'b0) |-> (rd_data[0] == 1'b0));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en || !frame_act) |=> (!edge_tick && sclk == idle_pol));

    // R5
    sclk_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tick && port_en && frame_act) |=> (sclk != $past(sclk)));

    // R5
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !edge_tick && port_en && frame_act) |=> $stable(sclk));

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && port_en && frame_act) |=> ($stable(act_half_m1) && $stable(act_rate)));

endmodule

bind bitrate_gen bitrate_gen_chk #(
    .PRE_W (PRE_W),
    .RATE_W(RATE_W),
    .RD_W  (RD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .frame_act  (frame_act),
    .idle_pol   (idle_pol),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .edge_tick  (edge_tick),
    .sclk       (sclk),
    .running    (running),
    .act_half_m1(act_half_m1),
    .act_rate   (act_rate)
);

// File: tb/bitrate_gen_tb_top.sv
module bitrate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       frame_act = 1'b0;
    logic       idle_pol = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       edge_tick;
    logic       sclk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    bitrate_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_en  (port_en),
        .frame_act(frame_act),
        .idle_pol (idle_pol),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .edge_tick(edge_tick),
        .sclk     (sclk)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    // R9 reset state
    task automatic t_reset();
        logic [7:0] d;
        read_reg(1'b0, d);
        chk(d == 8'd2, "R9 prescale reset", d, 2);
        read_reg(1'b1, d);
        chk(d == 8'd0, "R9 rate reset", d, 0);
        chk(edge_tick == 1'b0, "R9 tick reset", edge_tick, 0);
        chk(sclk == idle_pol, "R9 sclk reset", sclk, idle_pol);
    endtask

    // R1 / R2 register access
    task automatic t_regs();
        logic [7:0] d;
        write_reg(1'b0, 8'h37);
        read_reg(1'b0, d);
        chk(d == 8'h36, "R1 odd write cleared", d, 8'h36);
        write_reg(1'b0, 8'hFF);
        read_reg(1'b0, d);
        chk(d == 8'hFE, "R1 max write cleared", d, 8'hFE);
        write_reg(1'b1, 8'hFF);
        read_reg(1'b1, d);
        chk(d == 8'hFF, "R2 rate 255", d, 8'hFF);
        write_reg(1'b1, 8'h00);
        read_reg(1'b1, d);
        chk(d == 8'h00, "R2 rate 0", d, 0);
        read_reg(1'b0, d);
        chk(d == 8'hFE, "R2 rate write left prescale", d, 8'hFE);
    endtask

    // R3 / R5 / R7: start a frame and time three pulses
    task automatic run_frame(input int h, input logic pol, input string tag);
        int   t[3];
        int   n = 0;
        logic hist[0:1023];
        @(negedge clk);
        idle_pol = pol; port_en = 1'b1; frame_act = 1'b1;
        for (int i = 1; i <= 3*h + 2 && i < 1024; i++) begin
            @(posedge clk); #1;
            hist[i] = sclk;
            if (edge_tick && n < 3) begin
                t[n] = i;
                n++;
            end
        end
        chk(n == 3, {tag, " R3 pulse count"}, n, 3);
        if (n == 3) begin
            chk(t[0] == h, {tag, " R3 R7 first pulse cycle"}, t[0], h);
            chk(t[1] - t[0] == h, {tag, " R3 spacing 1"}, t[1] - t[0], h);
            chk(t[2] - t[1] == h, {tag, " R3 spacing 2"}, t[2] - t[1], h);
            chk(hist[t[0]] == pol, {tag, " R5 level before first flip"}, hist[t[0]], pol);
            chk(hist[t[0]+1] == ~pol, {tag, " R5 first flip"}, hist[t[0]+1], ~pol);
            chk(hist[t[1]+1] == pol, {tag, " R5 second flip"}, hist[t[1]+1], pol);
        end
    endtask

    // R6 / R7: stop the frame and watch the idle outputs
    task automatic stop_frame(input string tag);
        int bad = 0;
        @(negedge clk);
        frame_act = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (edge_tick || sclk != idle_pol) bad++;
        end
        chk(bad == 0, {tag, " R6 R7 idle after stop"}, bad, 0);
    endtask

    task automatic t_rates();
        write_reg(1'b0, 8'd2);   write_reg(1'b1, 8'd0);
        run_frame(1, 1'b0, "P2R0");   stop_frame("P2R0");
        write_reg(1'b0, 8'd4);   write_reg(1'b1, 8'd2);
        run_frame(6, 1'b1, "P4R2");   stop_frame("P4R2");
        write_reg(1'b0, 8'd6);   write_reg(1'b1, 8'd0);
        run_frame(3, 1'b0, "P6R0");   stop_frame("P6R0");
        write_reg(1'b0, 8'd254); write_reg(1'b1, 8'd1);
        run_frame(254, 1'b1, "P254R1"); stop_frame("P254R1");
        // R4: stored zero acts as 2
        write_reg(1'b0, 8'd0);   write_reg(1'b1, 8'd3);
        run_frame(4, 1'b0, "R4 P0R3"); stop_frame("R4 P0R3");
        // R1: odd write 5 runs as 4
        write_reg(1'b0, 8'd5);   write_reg(1'b1, 8'd1);
        run_frame(4, 1'b1, "R1 P5R1"); stop_frame("R1 P5R1");
    endtask

    // R8: writes during a frame wait for the next frame
    task automatic t_midframe();
        int gap = 0;
        int w = 0;
        write_reg(1'b0, 8'd4); write_reg(1'b1, 8'd1);
        run_frame(4, 1'b0, "R8 pre");
        write_reg(1'b0, 8'd8); write_reg(1'b1, 8'd3);
        while (!edge_tick && w < 2000) begin @(posedge clk); #1; w++; end
        do begin @(posedge clk); #1; gap++; end while (!edge_tick && gap < 2000);
        chk(gap == 4, "R8 spacing kept mid-frame", gap, 4);
        stop_frame("R8");
        run_frame(16, 1'b0, "R8 R7 next frame");
        stop_frame("R8 next");
    endtask

    // R6: port disabled with frame active stays quiet
    task automatic t_gate();
        int bad = 0;
        @(negedge clk);
        port_en = 1'b0; frame_act = 1'b1; idle_pol = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #1;
            if (edge_tick || sclk != 1'b1) bad++;
        end
        chk(bad == 0, "R6 disabled port quiet", bad, 0);
        @(negedge clk);
        idle_pol = 1'b0;
        #1;
        chk(sclk == 1'b0, "R6 idle level follows polarity", sclk, 0);
        frame_act = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_rates();
        t_midframe();
        t_gate();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule